// File: doc/BRIEF.md
# Two-Device TDM Daisy-Chain Merger

This block lets two converters share a single 8-slot serial TDM line. Each frame is 256 BICK periods long. The upstream unit sends its four channels as 32-bit slots in the first half of its own frame, and that stream enters this block on `tdmIn`. The block sends its own four channels first, as slots 0 to 3. It then repeats the upstream unit's four slots as slots 4 to 7. Only two devices can be chained, and only in the 256-BICK frame format. At a 48 kHz frame rate this gives 8 channels.

The block runs on a fast system clock. BICK, LRCK and the serial input are sampled as ordinary inputs. A rising BICK edge captures input bits. A falling BICK edge launches output bits. A frame begins at the first BICK rising edge that sees LRCK high after it was low. Upstream bits that arrive during the first 128 BICKs of a frame are stored and sent again in the upper half of the next frame. Output is held low until the block has seen a whole frame boundary.

Top module: `tdm_chain_merge`

## Requirements
- R1: `sdOut` is low during reset, before any frame start, and for the whole first frame after the first frame start.
- R2: Slot s (s = 0..3) of every later frame carries local channel s, which is `localData[24*s +: 24]`. The word is sent MSB first in slot bit positions 0 to 23, and positions 24 to 31 of the slot are zero.
- R3: Frame positions 128 to 255 repeat, bit for bit and in order, the `tdmIn` bits captured at positions 0 to 127 of the frame before.
- R4: In the first frame that carries data (the second frame after the first frame start), positions 128 to 255 are zero.
- R5: `tdmIn` bits at positions 128 to 255 of a frame are ignored. They never appear on `sdOut`.
- R6: When `tdmIn` is held low for a whole frame, positions 128 to 255 of the next frame are zero.
- R7: `localData` is captured once, when position 0 of a frame is launched. A change later in the frame has no effect on that frame.
- R8: Only an LRCK rising edge, as seen at a BICK rising edge, restarts the frame count. LRCK staying high for more than one BICK does not restart it again.
- R9: `sdOut` changes only in the system-clock cycle right after a falling BICK edge is detected. Input is captured only on rising BICK edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Must be much faster than BICK. |
| rstN | input | 1 | Active-low synchronous reset |
| bick | input | 1 | Serial bit clock, 256 periods per frame |
| lrck | input | 1 | Frame sync. A rising edge marks position 0. |
| tdmIn | input | 1 | Serial TDM stream from the upstream device |
| localData | input | 96 | Four 24-bit local samples. Channel s is in bits [24*s +: 24]. |
| sdOut | output | 1 | Merged 8-slot serial output |

## Verification
Some properties are checked by assertions on every cycle:
- the output changes only after a falling BICK edge;
- rising and falling edge strobes never occur in the same cycle;
- nothing is launched before the block is in sync;
- pad bits 24 to 31 of each local slot are zero;
- the count restarts at position 0 when LRCK rises;
- the upstream replay buffer is empty when the first data frame is loaded.

Other behaviour can only be shown by the bench scenarios, which decode whole frames:
- the local channels appear in the right slot order;
- the upstream bits are repeated exactly one frame later;
- the upstream second half is dropped;
- a mid-frame change to `localData` is ignored;
- an LRCK pulse that lasts many BICKs does not restart the frame.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;
  localparam int CH_PER_DEV = 4;
  localparam int SLOT_BITS  = 32;
  localparam int WORD_BITS  = 24;
  localparam int HALF_BITS  = CH_PER_DEV * SLOT_BITS;
  localparam int FRAME_BITS = 2 * HALF_BITS;
  localparam int LOCAL_BITS = CH_PER_DEV * WORD_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int CAP_W      = $clog2(HALF_BITS);
  localparam int SLOT_W     = $clog2(SLOT_BITS);
  localparam int LIDX_W     = $clog2(LOCAL_BITS);

  typedef struct packed {
    logic             sampleEn;
    logic [POS_W-1:0] samplePos;
    logic             launchEn;
    logic [POS_W-1:0] launchPos;
    logic             frameLoad;
  } strobe_t;
endpackage

// File: rtl/tdm_chain_ctrl.sv
module tdm_chain_ctrl
  import tdm_chain_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bick,
  input  logic    lrck,
  output strobe_t st
);
  logic             bickQ, bickQ2, lrckQ, lrckLast, synced;
  logic [POS_W-1:0] rxPos;
  logic             riseC, fallC, frameEdgeC;
  logic [POS_W-1:0] samplePosC, launchPosC;

  assign riseC      = bickQ & ~bickQ2;
  assign fallC      = ~bickQ & bickQ2;
  assign frameEdgeC = lrckQ & ~lrckLast;
  assign samplePosC = frameEdgeC ? '0 : rxPos + 1'b1;
  assign launchPosC = rxPos + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bickQ    <= 1'b0;
      bickQ2   <= 1'b0;
      lrckQ    <= 1'b0;
      lrckLast <= 1'b0;
      synced   <= 1'b0;
      rxPos    <= '0;
    end else begin
      bickQ  <= bick;
      bickQ2 <= bickQ;
      lrckQ  <= lrck;
      if (riseC) begin
        lrckLast <= lrckQ;
        rxPos    <= samplePosC;
        if (frameEdgeC) synced <= 1'b1;
      end
    end
  end

  always_comb begin
    st.sampleEn  = riseC;
    st.samplePos = samplePosC;
    st.launchEn  = fallC & synced;
    st.launchPos = launchPosC;
    st.frameLoad = fallC & synced & (launchPosC == '0);
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(st.sampleEn && st.launchEn)); // R9
  AST_NO_LAUNCH_UNSYNCED: assert property (@(posedge clk) disable iff (!rstN)
    !synced |-> !st.launchEn); // R1
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (riseC && lrckQ && !lrckLast) |=> (rxPos == '0)); // R8
endmodule

// File: rtl/tdm_chain_dp.sv
module tdm_chain_dp
  import tdm_chain_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               st,
  input  logic                  tdmIn,
  input  logic [LOCAL_BITS-1:0] localData,
  output logic                  sdOut
);
  logic                  tdmQ, loaded;
  logic [HALF_BITS-1:0]  capBuf, replay;
  logic [LOCAL_BITS-1:0] localHold, srcLocal;
  logic [CAP_W-1:0]      capIdx, replayIdx;
  logic [CAP_W-SLOT_W-1:0] slotIdx;
  logic [SLOT_W-1:0]     bitIdx;
  logic [LIDX_W-1:0]     localIdx;
  logic                  bitC;

  assign capIdx    = CAP_W'(HALF_BITS - 1) - st.samplePos[CAP_W-1:0];
  assign replayIdx = CAP_W'(HALF_BITS - 1) - st.launchPos[CAP_W-1:0];
  assign slotIdx   = st.launchPos[CAP_W-1:SLOT_W];
  assign bitIdx    = st.launchPos[SLOT_W-1:0];
  assign localIdx  = LIDX_W'(slotIdx) * LIDX_W'(WORD_BITS)
                   + LIDX_W'(WORD_BITS - 1) - LIDX_W'(bitIdx);
  assign srcLocal  = st.frameLoad ? localData : localHold;

  always_comb begin
    if (st.launchPos[POS_W-1])
      bitC = replay[replayIdx];
    else if (bitIdx < SLOT_W'(WORD_BITS))
      bitC = srcLocal[localIdx];
    else
      bitC = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tdmQ      <= 1'b0;
      loaded    <= 1'b0;
      capBuf    <= '0;
      replay    <= '0;
      localHold <= '0;
      sdOut     <= 1'b0;
    end else begin
      tdmQ <= tdmIn;
      if (st.sampleEn && loaded && !st.samplePos[POS_W-1])
        capBuf[capIdx] <= tdmQ;
      if (st.frameLoad) begin
        localHold <= localData;
        replay    <= capBuf;
        loaded    <= 1'b1;
      end
      if (st.launchEn)
        sdOut <= (loaded | st.frameLoad) & bitC;
    end
  end

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOut) |-> $past(st.launchEn)); // R9
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (st.launchEn && !st.launchPos[POS_W-1] && (bitIdx >= SLOT_W'(WORD_BITS))) |=> !sdOut); // R2
  AST_FIRST_UP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (st.frameLoad && !loaded) |=> (replay == '0)); // R4
endmodule

// File: rtl/tdm_chain_merge.sv
module tdm_chain_merge
  import tdm_chain_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bick,
  input  logic                  lrck,
  input  logic                  tdmIn,
  input  logic [LOCAL_BITS-1:0] localData,
  output logic                  sdOut
);
  strobe_t st;

  tdm_chain_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .bick (bick),
    .lrck (lrck),
    .st   (st)
  );

  tdm_chain_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .tdmIn     (tdmIn),
    .localData (localData),
    .sdOut     (sdOut)
  );
endmodule

// File: tb/tdm_chain_merge_tb.sv
module tdm_chain_merge_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bick = 1'b0;
  logic        lrck = 1'b0;
  logic        tdmIn = 1'b0;
  logic [95:0] localData = '0;
  logic        sdOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [255:0] prevUp;
  logic [255:0] got;

  always #2.5 clk = ~clk;

  tdm_chain_merge u_dut (
    .clk(clk), .rstN(rstN), .bick(bick), .lrck(lrck),
    .tdmIn(tdmIn), .localData(localData), .sdOut(sdOut)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [95:0] rnd96();
    return {$urandom, $urandom, $urandom};
  endfunction

  // One BICK period: falling half drives inputs, sample sdOut just before rise
  task automatic bitPeriod(input logic lv, input logic tv, output logic ob);
    @(negedge clk);
    bick = 1'b0; lrck = lv; tdmIn = tv;
    repeat (4) @(negedge clk);
    ob = sdOut;
    bick = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic runFrame(input logic [95:0] loc, input logic [255:0] up, input int hiBits,
                          input bit midChange, input logic [95:0] loc2);
    logic ob;
    localData = loc;
    for (int p = 0; p < 256; p++) begin
      if (midChange && p == 100) localData = loc2;
      bitPeriod(p < hiBits, up[255-p], ob);
      got[255-p] = ob;
    end
  endtask

  function automatic logic [255:0] expFrame(input logic [95:0] loc, input logic [127:0] upHalf);
    return {loc[23:0], 8'h00, loc[47:24], 8'h00, loc[71:48], 8'h00, loc[95:72], 8'h00, upHalf};
  endfunction

  task automatic checkFrame(input logic [255:0] exp, input string tagLo, input string tagUp);
    for (int s = 0; s < 8; s++) begin
      logic [31:0] a, e;
      a = got[255-32*s -: 32];
      e = exp[255-32*s -: 32];
      check(a == e, $sformatf("%s slot %0d", (s < 4) ? tagLo : tagUp, s), a, e);
    end
  endtask

  task automatic t_reset();
    check(sdOut == 1'b0, "R1 reset", {31'd0, sdOut}, 32'd0);
  endtask

  task automatic t_idle();
    logic ob;
    logic [31:0] acc = '0;
    for (int i = 0; i < 20; i++) begin
      bitPeriod(1'b0, $urandom_range(0, 1), ob);
      acc[i] = ob;
    end
    check(acc == 0, "R1 idle before sync", acc, 32'd0);
  endtask

  task automatic t_firstFrame();
    logic [255:0] up = rnd256();
    runFrame(rnd96(), up, 1, 1'b0, '0);
    checkFrame('0, "R1 first frame", "R1 first frame");
  endtask

  task automatic t_firstMerged();
    logic [95:0] loc = rnd96();
    prevUp = rnd256();
    runFrame(loc, prevUp, 1, 1'b0, '0);
    checkFrame(expFrame(loc, '0), "R2 local", "R4 first merged");
  endtask

  task automatic t_replay();
    logic [95:0] loc = rnd96();
    logic [255:0] up = rnd256();
    runFrame(loc, up, 1, 1'b0, '0);
    checkFrame(expFrame(loc, prevUp[255:128]), "R2 local", "R3 replay");
    prevUp = up;
  endtask

  task automatic t_midChange();
    logic [95:0] loc = rnd96();
    runFrame(loc, '0, 1, 1'b1, ~loc);
    checkFrame(expFrame(loc, prevUp[255:128]), "R7 mid-frame change", "R5 second half dropped");
    prevUp = '0;
  endtask

  task automatic t_longSync();
    logic [95:0] loc = rnd96();
    runFrame(loc, '0, 40, 1'b0, '0);
    checkFrame(expFrame(loc, '0), "R8 long sync", "R6 tied low");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_idle();
    t_firstFrame();
    t_firstMerged();
    t_replay();
    t_midChange();
    t_longSync();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule